// File: doc/BRIEF.md
# Run-time Configurable Approximate Adder

This block adds two unsigned operands and gives a sum and a carry-out. The arithmetic style is picked on every cycle by a mode code. Some modes are exact. Others make the low-order bits cheaper by dropping or limiting carry propagation.

Three controls shape the result:
- A boundary input sets how many of the low bits are treated approximately in the two lower-part modes.
- A segmented mode adds fixed-width slices independently.
- A short-window mode forms each carry from only a few neighbouring bit positions.

Operands, mode and boundary are sampled on a clock edge. The result appears on the registered outputs after that edge.

Top module: `apx_cfg_adder`

## Requirements
- R1: With mode code 0, `{cout_o, sum_o}` equals `opnd_a + opnd_b` as a WIDTH+1-bit value. It is visible one clock edge after the inputs are sampled.
- R2: With mode code 1 and clamped boundary n, result bits below n are `opnd_a | opnd_b`. Bits at and above n come from a normal addition of the upper operand bits. That addition's carry-in is `opnd_a[n-1] & opnd_b[n-1]`, or 0 when n is 0. `cout_o` is the carry out of bit WIDTH-1.
- R3: With mode code 2, bits below n are `opnd_a ^ opnd_b`, with no carry taken into them. The upper part and `cout_o` follow the same rule as in R2.
- R4: A boundary value greater than WIDTH acts exactly like WIDTH. With WIDTH=16 and boundary 16 or 31 in mode 1, `sum_o = opnd_a | opnd_b` and `cout_o = opnd_a[15] & opnd_b[15]`.
- R5: A boundary of 0 in mode 1 or mode 2 gives the exact sum and carry.
- R6: With mode code 3, the operands are cut into SEG_W-bit slices from bit 0 upward. Each slice is added with carry-in 0 and its carry-out is dropped. `cout_o` is the carry out of the top slice.
- R7: With mode code 4, the carry into bit i is the carry produced by adding only bits max(0, i-LOOK_K) to i-1 of both operands, with carry-in 0. Each sum bit is `a ^ b ^` that carry, and `cout_o` uses the same rule with i = WIDTH. The low LOOK_K bits are therefore always exact.
- R8: The boundary input has no effect in mode codes 0, 3 and 4.
- R9: Mode codes 5, 6 and 7 give the exact result, the same as code 0.
- R10: While `rst_n` is low, `sum_o` and `cout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| mode_sel | input | 3 | Arithmetic style: 0 exact, 1 lower OR, 2 lower XOR, 3 segmented, 4 short-window carry, 5-7 exact |
| lsb_bound | input | $clog2(WIDTH+1) | Number of approximate low bits for modes 1 and 2; clamped to WIDTH |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
The block holds no state apart from the output register. Any fault in a datapath therefore shows on `sum_o` or `cout_o` on the edge right after the offending operands are sampled.

A wrong boundary mask or wrong injected carry shifts bits just above the boundary. A window that is one bit too short or too long only shows up on operands with a carry chain near LOOK_K bits. A segment carry that leaks or is lost shows on slice-edge patterns such as 0x000F + 0x0001. For these reasons the stimulus mixes long propagate runs with random operands.

// File: rtl/apx_add_pkg.sv
package apx_add_pkg;

    typedef enum logic [2:0] {
        MODE_EXACT     = 3'd0,
        MODE_LOW_OR    = 3'd1,
        MODE_LOW_XOR   = 3'd2,
        MODE_SEGMENT   = 3'd3,
        MODE_LOOKAHEAD = 3'd4
    } apx_mode_e;

endpackage

// File: rtl/apx_lowpart.sv
// Lower-part approximation: bits below the boundary are OR or XOR,
// the upper part is a true adder with an injected carry.
module apx_lowpart #(
    parameter int WIDTH = 16,
    parameter int BND_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [BND_W-1:0] bnd,
    input  logic             use_xor,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] low_mask;
    logic [EW-1:0] edge_bit;
    logic [EW-1:0] up_a;
    logic [EW-1:0] up_b;
    logic [EW-1:0] inj;
    logic [EW-1:0] approx_bits;
    logic [EW-1:0] total;
    logic          cin;

    always_comb begin
        low_mask    = (EW'(1) << bnd) - EW'(1);
        edge_bit    = low_mask ^ (low_mask >> 1);
        cin         = |(edge_bit & {1'b0, a} & {1'b0, b});
        up_a        = {1'b0, a} & ~low_mask;
        up_b        = {1'b0, b} & ~low_mask;
        inj         = cin ? (EW'(1) << bnd) : '0;
        approx_bits = use_xor ? ({1'b0, a} ^ {1'b0, b}) : ({1'b0, a} | {1'b0, b});
        total       = (up_a + up_b + inj) | (approx_bits & low_mask);
        sum         = total[WIDTH-1:0];
        cout        = total[WIDTH];
    end
endmodule

// File: rtl/apx_segment.sv
// Independent slice addition; inter-slice carries are discarded.
module apx_segment #(
    parameter int WIDTH = 16,
    parameter int SEG_W = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NSEG = WIDTH / SEG_W;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g == NSEG - 1) begin : g_top
            assign {cout, sum[g*SEG_W +: SEG_W]} =
                {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]};
        end else begin : g_mid
            assign sum[g*SEG_W +: SEG_W] = a[g*SEG_W +: SEG_W] + b[g*SEG_W +: SEG_W];
        end
    end
endmodule

// File: rtl/apx_lookahead.sv
// Short-window carry: each carry sees only the LOOK_K positions below it.
module apx_lookahead #(
    parameter int WIDTH  = 16,
    parameter int LOOK_K = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] carry_v;

    always_comb begin
        carry_v = '0;
        for (int i = 1; i <= WIDTH; i++) begin
            int   lo;
            logic run;
            lo  = (i > LOOK_K) ? (i - LOOK_K) : 0;
            run = 1'b0;
            for (int j = 0; j < WIDTH; j++) begin
                if (j >= lo && j < i) begin
                    run = (a[j] & b[j]) | ((a[j] ^ b[j]) & run);
                end
            end
            carry_v[i] = run;
        end
        sum  = a ^ b ^ carry_v[WIDTH-1:0];
        cout = carry_v[WIDTH];
    end
endmodule

// File: rtl/apx_cfg_adder.sv
module apx_cfg_adder
    import apx_add_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int SEG_W  = 4,
    parameter int LOOK_K = 4,
    parameter int BND_W  = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       mode_sel,
    input  logic [BND_W-1:0] lsb_bound,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int                KLOW     = (LOOK_K < WIDTH) ? LOOK_K : WIDTH;
    localparam logic [WIDTH-1:0]  K_MASK   = WIDTH'((64'd1 << KLOW) - 64'd1);
    localparam logic [WIDTH-1:0]  SEG_MASK = WIDTH'((64'd1 << SEG_W) - 64'd1);

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } res_t;

    res_t             res_d, res_q;
    logic [BND_W-1:0] bnd_c;
    logic [WIDTH-1:0] low_sum, seg_sum, la_sum;
    logic             low_co, seg_co, la_co;

    assign bnd_c = (lsb_bound > BND_W'(WIDTH)) ? BND_W'(WIDTH) : lsb_bound;

    apx_lowpart #(.WIDTH(WIDTH), .BND_W(BND_W)) u_low (
        .a(opnd_a), .b(opnd_b), .bnd(bnd_c),
        .use_xor(mode_sel == MODE_LOW_XOR),
        .sum(low_sum), .cout(low_co)
    );

    apx_segment #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_seg (
        .a(opnd_a), .b(opnd_b), .sum(seg_sum), .cout(seg_co)
    );

    apx_lookahead #(.WIDTH(WIDTH), .LOOK_K(LOOK_K)) u_la (
        .a(opnd_a), .b(opnd_b), .sum(la_sum), .cout(la_co)
    );

    always_comb begin
        res_d = {1'b0, opnd_a} + {1'b0, opnd_b};
        case (mode_sel)
            MODE_LOW_OR, MODE_LOW_XOR: res_d = {low_co, low_sum};
            MODE_SEGMENT:              res_d = {seg_co, seg_sum};
            MODE_LOOKAHEAD:            res_d = {la_co, la_sum};
            default:                   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;

    initial begin
        assert (WIDTH % SEG_W == 0) else $error("WIDTH must be a multiple of SEG_W");
    end

    assert_exact_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0) |=> ({cout_o, sum_o} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    assert_or_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1 && lsb_bound != 0) |=> (sum_o[0] == ($past(opnd_a[0]) | $past(opnd_b[0]))));

    assert_xor_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd2 && lsb_bound != 0) |=> (sum_o[0] == ($past(opnd_a[0]) ^ $past(opnd_b[0]))));

    assert_clamp_full_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1 && lsb_bound >= BND_W'(WIDTH)) |=>
        (sum_o == ($past(opnd_a) | $past(opnd_b)) &&
         cout_o == ($past(opnd_a[WIDTH-1]) & $past(opnd_b[WIDTH-1]))));

    assert_zero_bound_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 3'd1 || mode_sel == 3'd2) && lsb_bound == 0) |=>
        ({cout_o, sum_o} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    assert_low_slice_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd3) |=> (((sum_o ^ ($past(opnd_a) + $past(opnd_b))) & SEG_MASK) == '0));

    assert_window_low_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd4) |=> (((sum_o ^ ($past(opnd_a) + $past(opnd_b))) & K_MASK) == '0));

    assert_spare_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel >= 3'd5) |=> ({cout_o, sum_o} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));
endmodule

// File: tb/apx_cfg_adder_test.sv
`timescale 1ns/1ps
module apx_cfg_adder_test;
    localparam int W = 16;
    localparam int SW = 4;
    localparam int K = 4;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic [2:0]    m = '0;
    logic [BW-1:0] bd = '0;
    logic [W-1:0]  sum_o;
    logic          cout_o;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    apx_cfg_adder #(.WIDTH(W), .SEG_W(SW), .LOOK_K(K)) uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b),
        .mode_sel(m), .lsb_bound(bd), .sum_o(sum_o), .cout_o(cout_o)
    );

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [2:0] md, input logic [BW-1:0] bq);
        int xi = int'(x);
        int yi = int'(y);
        int n = (int'(bq) > W) ? W : int'(bq);
        int r = 0;
        case (md)
            3'd1, 3'd2: begin
                int cin = (n > 0) ? (((xi >> (n - 1)) & (yi >> (n - 1))) & 1) : 0;
                int up = (((xi >> n) + (yi >> n) + cin) << n);
                int lo = ((md == 3'd1) ? (xi | yi) : (xi ^ yi)) & ((1 << n) - 1);
                r = up + lo;
            end
            3'd3: begin
                for (int s = 0; s < W / SW; s++) begin
                    int sv = ((xi >> (SW * s)) & ((1 << SW) - 1)) + ((yi >> (SW * s)) & ((1 << SW) - 1));
                    r |= (sv & ((1 << SW) - 1)) << (SW * s);
                    if (s == W / SW - 1) r |= (sv >> SW) << W;
                end
            end
            3'd4: begin
                for (int i = 0; i <= W; i++) begin
                    int lo = (i > K) ? i - K : 0;
                    int len = i - lo;
                    int c = (((((xi >> lo) & ((1 << len) - 1)) + ((yi >> lo) & ((1 << len) - 1))) >> len) & 1);
                    if (i < W) r |= ((((xi >> i) ^ (yi >> i)) & 1) ^ c) << i;
                    else       r |= c << W;
                end
            end
            default: r = xi + yi;
        endcase
        return r[W:0];
    endfunction

    function automatic string tag(input logic [2:0] md, input logic [BW-1:0] bq);
        case (md)
            3'd0: return "R1";
            3'd1: return (bq == 0) ? "R5" : ((bq > W) ? "R4" : "R2");
            3'd2: return (bq == 0) ? "R5" : "R3";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [W:0] exp);
        n_chk++;
        if ({cout_o, sum_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h mode=%0d bound=%0d got=%h expected=%h",
                     req, a, b, m, bd, {cout_o, sum_o}, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [2:0] md, input logic [BW-1:0] bq, input string req);
        a = x; b = y; m = md; bd = bq;
        @(negedge clk);
        check(req, model(x, y, md, bq));
    endtask

    initial begin
        void'($urandom(32'd2024));
        a = 16'hFFFF; b = 16'h0001; m = 3'd0;
        repeat (3) @(negedge clk);
        check("R10", '0);                       // R10 reset holds zero
        rst_n = 1'b1;
        @(negedge clk);
        apply(16'hFFFF, 16'h0001, 3'd0, 5'd0, "R1");
        check("R1", 17'h10000);
        apply(16'h00F0, 16'h0F0F, 3'd1, 5'd8, "R2");
        apply(16'h1234, 16'h00FF, 3'd1, 5'd4, "R2");
        apply(16'h0018, 16'h0008, 3'd2, 5'd4, "R3");
        apply(16'hFFFF, 16'h8001, 3'd1, 5'd16, "R4");
        check("R4", 17'h1FFFF);
        apply(16'hFFFF, 16'h8001, 3'd1, 5'd31, "R4");
        check("R4", 17'h1FFFF);
        apply(16'hABCD, 16'h6789, 3'd1, 5'd0, "R5");
        apply(16'hABCD, 16'h6789, 3'd2, 5'd0, "R5");
        apply(16'h000F, 16'h0001, 3'd3, 5'd0, "R6");
        check("R6", 17'h00000);
        apply(16'hF000, 16'h1000, 3'd3, 5'd0, "R6");
        check("R6", 17'h10000);
        apply(16'h7FFF, 16'h0001, 3'd4, 5'd0, "R7");
        check("R7", 17'h07FE0);
        apply(16'h0007, 16'h0001, 3'd4, 5'd0, "R7");
        check("R7", 17'h00008);
        // R8: boundary changes do not alter modes 0, 3, 4
        for (int md = 0; md < 5; md++) begin
            if (md == 1 || md == 2) continue;
            apply(16'h5A5F, 16'h3CF1, 3'(md), 5'd0, "R8");
            apply(16'h5A5F, 16'h3CF1, 3'(md), 5'd9, "R8");
            apply(16'h5A5F, 16'h3CF1, 3'(md), 5'd31, "R8");
        end
        for (int md = 5; md < 8; md++) apply(16'hFFFF, 16'hFFFF, 3'(md), 5'd7, "R9");
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] x = W'($urandom);
            logic [W-1:0] y = W'($urandom);
            logic [2:0]   md = 3'($urandom % 8);
            logic [BW-1:0] bq = BW'($urandom % 32);
            if ($urandom % 3 == 0) y = ~x ^ W'(1 << ($urandom % W));
            apply(x, y, md, bq, tag(md, bq));
        end
        rst_n = 1'b0;
        #1;
        check("R10", '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule